// File: doc/BRIEF.md
# One-Second Alarm Status Latch

This block gathers the live alarm indications of a line framer into one status word that a host reads. A read strobe returns the word one clock later. The block works in one of two modes. In sticky mode, any alarm seen since the previous read is reported, and the read clears the word. In interval mode, an external one-second timing input divides time into intervals. Alarms seen during one interval become readable only in the next interval.

In interval mode the first read in an interval returns the frozen snapshot. Any further read in the same interval returns the live alarm state and wipes what has been held so far. The line code violation flag bypasses both modes and is reported live in the top bit of every read.

Top module: `onesec_status_latch`

## Requirements
- R1: A synchronous active-high reset clears the held word, the interval staging register, the read phase (back to first read) and `rd_data_o` to all zeros.
- R2: `rd_data_o` is registered. It changes only at a clock edge where `rd_i` is high, so the read result appears one cycle after the strobe. Bits [ALARM_W-1:0] carry status and bit ALARM_W carries the line code violation flag.
- R3: Bit ALARM_W of every read result equals `lcv_i` as sampled in the read cycle, in either mode, without latching.
- R4: With `interval_en_i` low, the held word ORs in `alarm_i` on every cycle. A read returns the held word from before the edge and reloads it with the `alarm_i` of the read cycle, so an alarm present during the read is not lost.
- R5: `sec_pulse_i` passes through SYNC_STAGES synchronising flops. Each rising edge gives exactly one interval boundary, for any pulse length of one clock or more.
- R6: With `interval_en_i` high, alarms are ORed into a staging register. At a boundary the held word becomes held OR staging OR the `alarm_i` of that cycle, and staging clears. An alarm is therefore not readable in the interval in which it occurred.
- R7: Held bits that no read has cleared survive every later boundary.
- R8: In interval mode, the first read after a boundary returns the held word and clears it.
- R9: In interval mode, every further read in the same interval returns the live `alarm_i` and clears both the held word and staging.
- R10: When a read and a boundary fall on the same edge, the boundary transfer wins. The read returns the held word from before the transfer, clears nothing, and the next read counts as the first of the new interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| alarm_i | input | ALARM_W | Live alarm bits from the framer |
| lcv_i | input | 1 | Live line code violation flag |
| sec_pulse_i | input | 1 | Asynchronous one-second timing input |
| interval_en_i | input | 1 | 1 selects interval mode, 0 selects sticky mode |
| rd_i | input | 1 | Read strobe, one cycle per read |
| rd_data_o | output | ALARM_W+1 | Read result: {lcv, status} |

## Verification
Some properties are checked on every cycle:
- the read result holds between strobes;
- the live violation bit follows the strobe cycle;
- a boundary pulse never lasts two cycles;
- sticky gathering never drops a bit;
- a boundary copies all of staging;
- a repeat read returns live alarms;
- a read coinciding with a boundary returns the pre-transfer word.

Other behaviour shows only across whole scenarios, because it depends on a sequence of events:
- an alarm is hidden until the next interval;
- unread bits survive several boundaries;
- the first read clears the snapshot;
- a long timing pulse counts once, which the bench shows through a read that stays in its second-read phase.

// File: rtl/onesec_pkg.sv
package onesec_pkg;
   // Read phase inside one interval
   typedef enum logic {
      RD_FRESH = 1'b0,
      RD_AGAIN = 1'b1
   } rd_phase_e;

   function automatic logic [7:0] sync_depth_min();
      return 8'd2;
   endfunction
endpackage

// File: rtl/onesec_edge_sync.sv
module onesec_edge_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic async_i,
   output logic rise_o
);
   localparam int LAST = SYNC_STAGES - 1;

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], async_i};
         prev_q <= sync_q[LAST];
      end
   end

   assign rise_o = sync_q[LAST] & ~prev_q;
endmodule

// File: rtl/onesec_status_core.sv
module onesec_status_core
   import onesec_pkg::*;
#(
   parameter int ALARM_W = 8
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic [ALARM_W-1:0] alarm_i,
   input  logic               lcv_i,
   input  logic               tick_i,
   input  logic               interval_en_i,
   input  logic               rd_i,
   output logic [ALARM_W:0]   rd_data_o,
   output logic [ALARM_W-1:0] held_o,
   output logic [ALARM_W-1:0] stage_o,
   output rd_phase_e          phase_o
);
   logic [ALARM_W-1:0] held_q, stage_q;
   rd_phase_e          phase_q;
   logic [ALARM_W:0]   data_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         held_q  <= '0;
         stage_q <= '0;
         phase_q <= RD_FRESH;
         data_q  <= '0;
      end else if (!interval_en_i) begin
         stage_q <= '0;
         phase_q <= RD_FRESH;
         if (rd_i) begin
            data_q <= {lcv_i, held_q};
            held_q <= alarm_i;
         end else begin
            held_q <= held_q | alarm_i;
         end
      end else if (tick_i) begin
         held_q  <= held_q | stage_q | alarm_i;
         stage_q <= '0;
         phase_q <= RD_FRESH;
         if (rd_i) data_q <= {lcv_i, held_q};
      end else if (rd_i) begin
         if (phase_q == RD_FRESH) begin
            data_q  <= {lcv_i, held_q};
            held_q  <= '0;
            stage_q <= stage_q | alarm_i;
            phase_q <= RD_AGAIN;
         end else begin
            data_q  <= {lcv_i, alarm_i};
            held_q  <= '0;
            stage_q <= '0;
         end
      end else begin
         stage_q <= stage_q | alarm_i;
      end
   end

   assign rd_data_o = data_q;
   assign held_o    = held_q;
   assign stage_o   = stage_q;
   assign phase_o   = phase_q;
endmodule

// File: rtl/onesec_status_latch.sv
module onesec_status_latch
   import onesec_pkg::*;
#(
   parameter int ALARM_W     = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic [ALARM_W-1:0] alarm_i,
   input  logic               lcv_i,
   input  logic               sec_pulse_i,
   input  logic               interval_en_i,
   input  logic               rd_i,
   output logic [ALARM_W:0]   rd_data_o
);
   if (ALARM_W < 1) begin : g_bad_width
      $error("ALARM_W must be at least 1");
   end
   if (SYNC_STAGES < int'(sync_depth_min())) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic               tick_w;
   logic [ALARM_W-1:0] held_w, stage_w;
   rd_phase_e          phase_w;

   onesec_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .async_i (sec_pulse_i),
      .rise_o  (tick_w)
   );

   onesec_status_core #(.ALARM_W(ALARM_W)) u_core (
      .clk_i         (clk_i),
      .rst_i         (rst_i),
      .alarm_i       (alarm_i),
      .lcv_i         (lcv_i),
      .tick_i        (tick_w),
      .interval_en_i (interval_en_i),
      .rd_i          (rd_i),
      .rd_data_o     (rd_data_o),
      .held_o        (held_w),
      .stage_o       (stage_w),
      .phase_o       (phase_w)
   );
endmodule

// File: rtl/onesec_status_latch_chk.sv
module onesec_status_latch_chk
   import onesec_pkg::*;
#(
   parameter int ALARM_W = 8
) (
   input logic               clk_i,
   input logic               rst_i,
   input logic [ALARM_W-1:0] alarm_i,
   input logic               lcv_i,
   input logic               interval_en_i,
   input logic               rd_i,
   input logic [ALARM_W:0]   rd_data_o,
   input logic               tick_w,
   input logic [ALARM_W-1:0] held_w,
   input logic [ALARM_W-1:0] stage_w,
   input rd_phase_e          phase_w
);
   // R2
   rd_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !rd_i |=> $stable(rd_data_o));

   // R3
   lcv_pass_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      rd_i |=> rd_data_o[ALARM_W] == $past(lcv_i));

   // R5
   tick_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      tick_w |=> !tick_w);

   // R4
   sticky_gather_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !interval_en_i |=> (held_w & $past(alarm_i)) == $past(alarm_i));

   // R6
   edge_transfer_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (interval_en_i && tick_w) |=> (held_w & $past(stage_w)) == $past(stage_w));

   // R9
   live_read_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (interval_en_i && rd_i && !tick_w && phase_w == RD_AGAIN)
         |=> rd_data_o[ALARM_W-1:0] == $past(alarm_i));

   // R10
   edge_read_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (interval_en_i && rd_i && tick_w) |=> rd_data_o[ALARM_W-1:0] == $past(held_w));
endmodule

bind onesec_status_latch onesec_status_latch_chk #(.ALARM_W(ALARM_W)) u_chk (
   .clk_i         (clk_i),
   .rst_i         (rst_i),
   .alarm_i       (alarm_i),
   .lcv_i         (lcv_i),
   .interval_en_i (interval_en_i),
   .rd_i          (rd_i),
   .rd_data_o     (rd_data_o),
   .tick_w        (tick_w),
   .held_w        (held_w),
   .stage_w       (stage_w),
   .phase_w       (phase_w)
);

// File: tb/onesec_status_latch_tb.sv
module onesec_status_latch_tb;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] alarm = '0;
   logic         lcv = 1'b0;
   logic         sec = 1'b0;
   logic         ien = 1'b0;
   logic         rd = 1'b0;
   logic [W:0]   rd_data;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   logic [W:0] exp_q[$];
   string      tag_q[$];
   logic       pend = 1'b0;

   always #10 clk = ~clk;

   onesec_status_latch #(.ALARM_W(W), .SYNC_STAGES(2)) u_dut (
      .clk_i         (clk),
      .rst_i         (rst),
      .alarm_i       (alarm),
      .lcv_i         (lcv),
      .sec_pulse_i   (sec),
      .interval_en_i (ien),
      .rd_i          (rd),
      .rd_data_o     (rd_data)
   );

   task automatic check(input logic [W:0] act, input logic [W:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   // Driver: one read strobe, expected result goes to the scoreboard
   task automatic rd_expect(input logic [W:0] exp, input string req);
      @(negedge clk);
      rd = 1'b1;
      exp_q.push_back(exp);
      tag_q.push_back(req);
      @(negedge clk);
      rd = 1'b0;
   endtask

   task automatic pulse_alarm(input logic [W-1:0] v);
      @(negedge clk);
      alarm = v;
      @(negedge clk);
      alarm = '0;
   endtask

   task automatic sec_tick(input int len);
      @(negedge clk);
      sec = 1'b1;
      repeat (len) @(negedge clk);
      sec = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   // Monitor: compare one cycle after each strobe
   always @(posedge clk) pend <= rd;
   always @(negedge clk) begin
      if (pend) begin
         if (exp_q.size() == 0) begin
            check(rd_data, '0, "scoreboard-empty");
         end else begin
            check(rd_data, exp_q.pop_front(), tag_q.pop_front());
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 20000) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check(rd_data, '0, "R1 reset value");
      rd_expect(9'h000, "R1 read after reset");

      // Sticky mode
      pulse_alarm(8'h05);
      rd_expect(9'h005, "R4 sticky capture");
      rd_expect(9'h000, "R4 cleared by read");
      @(negedge clk); alarm = 8'h10;
      repeat (2) @(negedge clk);
      rd_expect(9'h010, "R4 held alarm");
      alarm = '0;
      rd_expect(9'h010, "R4 reload keeps alarm of read cycle");
      lcv = 1'b1;
      rd_expect(9'h100, "R3 live violation bit");
      lcv = 1'b0;
      pulse_alarm(8'h80);
      repeat (3) @(negedge clk);
      check(rd_data, 9'h100, "R2 result stable without strobe");
      rd_expect(9'h080, "R4 later alarm");

      // Interval mode
      @(negedge clk); ien = 1'b1;
      pulse_alarm(8'h03);
      rd_expect(9'h000, "R6 hidden in same interval");
      sec_tick(1);
      rd_expect(9'h003, "R6 visible next interval");
      @(negedge clk); alarm = 8'h40;
      repeat (2) @(negedge clk);
      rd_expect(9'h040, "R9 second read returns live");
      alarm = '0;
      sec_tick(1);
      rd_expect(9'h000, "R9 staging cleared by second read");
      pulse_alarm(8'h08);
      sec_tick(1);
      sec_tick(1);
      rd_expect(9'h008, "R7 unread kept across boundary");
      pulse_alarm(8'h11);
      sec_tick(1);
      rd_expect(9'h011, "R8 first read returns snapshot");
      sec_tick(1);
      rd_expect(9'h000, "R8 first read cleared snapshot");

      // Coincident read and boundary
      pulse_alarm(8'h20);
      @(negedge clk); sec = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rd = 1'b1;
      exp_q.push_back(9'h000);
      tag_q.push_back("R10 read at boundary returns old word");
      @(negedge clk);
      rd = 1'b0;
      sec = 1'b0;
      repeat (3) @(negedge clk);
      rd_expect(9'h020, "R10 next read is first of new interval");

      // Long timing pulse counts once
      pulse_alarm(8'h02);
      @(negedge clk); sec = 1'b1;
      repeat (5) @(negedge clk);
      rd_expect(9'h002, "R5 boundary on long pulse");
      pulse_alarm(8'h04);
      repeat (2) @(negedge clk);
      sec = 1'b0;
      repeat (5) @(negedge clk);
      rd_expect(9'h000, "R5 long pulse gives one boundary");

      repeat (3) @(negedge clk);
      check({8'h00, exp_q.size() != 0}, '0, "scoreboard drained");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule